// File: doc/BRIEF.md
# Descriptor Ring Source Engine

This block is the hardware consumer of a transmit descriptor ring held in memory. The host programs a ring base address, a power-of-two entry count, a per-descriptor length limit and a producer index through a small word-wide register port. Whenever its own consumer index differs from the producer index, the engine reads the next 8-byte descriptor through a request/ready memory port, checks it, and folds it into an outgoing transfer request. A run of descriptors marked for gathering is merged into one request. The run closes at the first unmarked descriptor.

Completion is visible only through the consumer index, which the host polls. That index moves forward only when the transfer request holding a descriptor has been accepted by the downstream mover. It moves by every ring entry the request consumed. A descriptor longer than the programmed limit is dropped and raises a sticky error flag. Every index wraps by masking with the entry count minus one.

The engine is a four-state machine. The states are IDLE, FETCH, CHECK and EMIT. IDLE goes to FETCH when the ring is configured and an entry is pending. FETCH goes to CHECK on the memory handshake. CHECK goes back to IDLE when a descriptor is dropped or opens or extends a gather run, and goes to EMIT when a descriptor closes a run. EMIT goes to IDLE when the request is accepted. A write to the size register forces IDLE from any state.

Top module: `dring_src_engine`

## Requirements
- R1: After reset the consumer index reads 0, the status and control registers read 0, and neither mem_req nor xfer_valid is asserted.
- R2: The control register at address 2 returns the length limit in bits 15:0 and the byte-swap enable in bit 16. A write to address 2 changes only the length limit. A write to address 6 changes only the byte-swap enable, taken from data bit 0.
- R3: While the base (address 0), size (address 1) or length limit is zero, no new descriptor fetch starts and the consumer index does not move.
- R4: A descriptor is fetched from base + 8*index and the index wraps through the mask (size − 1). The descriptor word holds the buffer address in bits 31:0 and the byte count in bits 47:32. Bits 63:48 hold the flags: id in 11:0, swap in bit 12, gather in bit 13.
- R5: A descriptor without the gather flag, with no run open, yields one request carrying its address, byte count and id, with xfer_cnt = 1. A byte count equal to the limit is accepted.
- R6: Gather-flagged descriptors are merged with the following ones up to and including the first unflagged descriptor. The request carries the first address and id, the sum of byte counts and the number of merged descriptors. Nothing is emitted while the run is still open.
- R7: xfer_swap is high when any merged descriptor has its swap flag set or the ring byte-swap enable is set.
- R8: A descriptor whose byte count exceeds the limit is dropped. It contributes nothing to any request and its gather flag is ignored. It sets status bit 0 (address 5), which stays set until 1 is written to that bit. The consumer index still passes over it.
- R9: The consumer index (address 4) advances only when a request is accepted, or immediately for a dropped descriptor outside a run. It advances by all the entries the request consumed, and holds while a request waits.
- R10: While xfer_valid is high and xfer_ready is low, xfer_valid and all request fields stay unchanged.
- R11: A write to the size register clears the producer index (address 3) and the consumer index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor byte address |
| mem_rdy | input | 1 | Memory accepts the request; mem_rdata valid |
| mem_rdata | input | 64 | Descriptor word |
| xfer_valid | output | 1 | Transfer request valid |
| xfer_ready | input | 1 | Mover accepts the request |
| xfer_addr | output | 32 | Buffer address of the first descriptor |
| xfer_len | output | LEN_W | Total byte count |
| xfer_id | output | 12 | Id of the first descriptor |
| xfer_swap | output | 1 | Byte-reverse each 32-bit data word |
| xfer_cnt | output | IDX_W+1 | Descriptors merged into the request |

## Verification
The engine is driven with random batches of single descriptors of varied size, which exercise index wrap with an 8-entry and a 4-entry ring. It is also driven with random gather runs, which separate correct summing and first-field capture from per-descriptor emission. Random oversize descriptors, both inside and outside runs, show whether a dropped entry is still consumed without reaching any request. Directed cases cover several points: the exact length limit, a run split across two producer-index writes, a request held back by the mover (index and fields must freeze), field-preserving control writes, and a deconfigured ring that must stay silent.

// File: rtl/dring_pkg.sv
package dring_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_CHECK = 2'd2,
        ST_EMIT  = 2'd3
    } eng_state_t;

    localparam int REG_AW     = 3;
    localparam int DESC_SHIFT = 3;   // 8 bytes per descriptor
    localparam int ID_W       = 12;
    localparam int SWAP_BIT   = 12;
    localparam int GATHER_BIT = 13;

    localparam logic [REG_AW-1:0] RA_BASE = 3'd0;
    localparam logic [REG_AW-1:0] RA_SIZE = 3'd1;
    localparam logic [REG_AW-1:0] RA_CTRL = 3'd2;
    localparam logic [REG_AW-1:0] RA_WIDX = 3'd3;
    localparam logic [REG_AW-1:0] RA_RIDX = 3'd4;
    localparam logic [REG_AW-1:0] RA_STAT = 3'd5;
    localparam logic [REG_AW-1:0] RA_SWAP = 3'd6;

    typedef struct packed {
        logic [15:0] flags;
        logic [15:0] nbytes;
        logic [31:0] buf_addr;
    } desc_t;

endpackage

// File: rtl/dring_regs.sv
module dring_regs
    import dring_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              err_set,
    output logic [31:0]       base,
    output logic [IDX_W-1:0]  idx_mask,
    output logic [15:0]       maxlen,
    output logic              swap_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              enabled,
    output logic              ring_clr
);
    localparam int SIZE_W = IDX_W + 1;

    logic [31:0]       base_q;
    logic [SIZE_W-1:0] size_q;
    logic [15:0]       maxlen_q;
    logic              swap_q;
    logic [IDX_W-1:0]  widx_q;
    logic              err_q;
    logic [SIZE_W-1:0] size_m1;
    logic              unused_size_top;

    logic wr_base, wr_size, wr_ctrl, wr_widx, wr_stat, wr_swap;

    assign wr_base = cfg_we && (cfg_addr == RA_BASE);
    assign wr_size = cfg_we && (cfg_addr == RA_SIZE);
    assign wr_ctrl = cfg_we && (cfg_addr == RA_CTRL);
    assign wr_widx = cfg_we && (cfg_addr == RA_WIDX);
    assign wr_stat = cfg_we && (cfg_addr == RA_STAT);
    assign wr_swap = cfg_we && (cfg_addr == RA_SWAP);

    assign size_m1         = size_q - 1'b1;
    assign idx_mask        = size_m1[IDX_W-1:0];
    assign unused_size_top = size_m1[SIZE_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q   <= '0;
            size_q   <= '0;
            maxlen_q <= '0;
            swap_q   <= 1'b0;
            widx_q   <= '0;
            err_q    <= 1'b0;
        end else begin
            if (wr_base) base_q <= {cfg_wdata[31:DESC_SHIFT], {DESC_SHIFT{1'b0}}};
            if (wr_size) begin
                size_q <= cfg_wdata[SIZE_W-1:0];
                widx_q <= '0;
            end else if (wr_widx) begin
                widx_q <= cfg_wdata[IDX_W-1:0] & idx_mask;
            end
            if (wr_ctrl) maxlen_q <= cfg_wdata[15:0];
            if (wr_swap) swap_q   <= cfg_wdata[0];
            if (err_set)                      err_q <= 1'b1;
            else if (wr_stat && cfg_wdata[0]) err_q <= 1'b0;
        end
    end

    always_comb begin
        case (cfg_addr)
            RA_BASE: cfg_rdata = base_q;
            RA_SIZE: cfg_rdata = 32'(size_q);
            RA_CTRL: cfg_rdata = {15'd0, swap_q, maxlen_q};
            RA_WIDX: cfg_rdata = 32'(widx_q);
            RA_RIDX: cfg_rdata = 32'(rd_idx);
            RA_STAT: cfg_rdata = {31'd0, err_q};
            RA_SWAP: cfg_rdata = {31'd0, swap_q};
            default: cfg_rdata = 32'd0;
        endcase
    end

    assign base     = base_q;
    assign maxlen   = maxlen_q;
    assign swap_en  = swap_q;
    assign wr_idx   = widx_q;
    assign ring_clr = wr_size;
    assign enabled  = (base_q != '0) && (size_q != '0) && (maxlen_q != '0);

endmodule

// File: rtl/dring_engine.sv
module dring_engine
    import dring_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int LEN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ring_clr,
    input  logic             enabled,
    input  logic [31:0]      base,
    input  logic [IDX_W-1:0] idx_mask,
    input  logic [15:0]      maxlen,
    input  logic             swap_en,
    input  logic [IDX_W-1:0] wr_idx,
    output logic             mem_req,
    output logic [31:0]      mem_addr,
    input  logic             mem_rdy,
    input  logic [63:0]      mem_rdata,
    output logic             xfer_valid,
    input  logic             xfer_ready,
    output logic [31:0]      xfer_addr,
    output logic [LEN_W-1:0] xfer_len,
    output logic [ID_W-1:0]  xfer_id,
    output logic             xfer_swap,
    output logic [IDX_W:0]   xfer_cnt,
    output logic [IDX_W-1:0] rd_idx,
    output logic             err_set
);
    localparam int CNT_W = IDX_W + 1;

    eng_state_t        state_q, state_d;
    logic [IDX_W-1:0]  rd_q, fetch_q;
    logic [CNT_W-1:0]  pend_q;
    logic              open_q;
    desc_t             desc_q;
    logic [31:0]       acc_addr;
    logic [LEN_W-1:0]  acc_len;
    logic [ID_W-1:0]   acc_id;
    logic              acc_swap;
    logic [CNT_W-1:0]  acc_cnt;
    logic              oversize, d_gather, d_swap;
    logic [1:0]        unused_flags;

    assign oversize     = desc_q.nbytes > maxlen;
    assign d_gather     = desc_q.flags[GATHER_BIT];
    assign d_swap       = desc_q.flags[SWAP_BIT];
    assign unused_flags = desc_q.flags[15:14];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (enabled && (fetch_q != wr_idx)) state_d = ST_FETCH;
            ST_FETCH: if (mem_rdy) state_d = ST_CHECK;
            ST_CHECK: state_d = (oversize || d_gather) ? ST_IDLE : ST_EMIT;
            ST_EMIT:  if (xfer_ready) state_d = ST_IDLE;
        endcase
        if (ring_clr) state_d = ST_IDLE;
    end

    // datapath: indices and run accumulation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q     <= '0;
            fetch_q  <= '0;
            pend_q   <= '0;
            open_q   <= 1'b0;
            desc_q   <= '0;
            acc_addr <= '0;
            acc_len  <= '0;
            acc_id   <= '0;
            acc_swap <= 1'b0;
            acc_cnt  <= '0;
        end else if (ring_clr) begin
            rd_q     <= '0;
            fetch_q  <= '0;
            pend_q   <= '0;
            open_q   <= 1'b0;
            acc_len  <= '0;
            acc_cnt  <= '0;
            acc_swap <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_FETCH: if (mem_rdy) desc_q <= mem_rdata;
                ST_CHECK: begin
                    fetch_q <= (fetch_q + 1'b1) & idx_mask;
                    if (oversize) begin
                        if (open_q) pend_q <= pend_q + 1'b1;
                        else        rd_q   <= (rd_q + 1'b1) & idx_mask;
                    end else begin
                        pend_q   <= pend_q + 1'b1;
                        acc_len  <= (open_q ? acc_len : '0) + LEN_W'(desc_q.nbytes);
                        acc_cnt  <= (open_q ? acc_cnt : '0) + 1'b1;
                        acc_swap <= (open_q && acc_swap) || d_swap;
                        if (!open_q) begin
                            acc_addr <= desc_q.buf_addr;
                            acc_id   <= desc_q.flags[ID_W-1:0];
                        end
                        open_q <= d_gather;
                    end
                end
                ST_EMIT: if (xfer_ready) begin
                    rd_q   <= (rd_q + pend_q[IDX_W-1:0]) & idx_mask;
                    pend_q <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req    = (state_q == ST_FETCH);
        xfer_valid = (state_q == ST_EMIT);
        err_set    = (state_q == ST_CHECK) && oversize;
    end

    assign mem_addr  = base + (32'(fetch_q) << DESC_SHIFT);
    assign xfer_addr = acc_addr;
    assign xfer_len  = acc_len;
    assign xfer_id   = acc_id;
    assign xfer_swap = acc_swap || swap_en;
    assign xfer_cnt  = acc_cnt;
    assign rd_idx    = rd_q;

endmodule

// File: rtl/dring_src_engine.sv
module dring_src_engine
    import dring_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int LEN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    output logic             mem_req,
    output logic [31:0]      mem_addr,
    input  logic             mem_rdy,
    input  logic [63:0]      mem_rdata,
    output logic             xfer_valid,
    input  logic             xfer_ready,
    output logic [31:0]      xfer_addr,
    output logic [LEN_W-1:0] xfer_len,
    output logic [11:0]      xfer_id,
    output logic             xfer_swap,
    output logic [IDX_W:0]   xfer_cnt
);
    logic [31:0]      base;
    logic [IDX_W-1:0] idx_mask;
    logic [15:0]      maxlen;
    logic             swap_en;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic             enabled;
    logic             ring_clr;
    logic             err_set;

    dring_regs #(.IDX_W(IDX_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .rd_idx   (rd_idx),
        .err_set  (err_set),
        .base     (base),
        .idx_mask (idx_mask),
        .maxlen   (maxlen),
        .swap_en  (swap_en),
        .wr_idx   (wr_idx),
        .enabled  (enabled),
        .ring_clr (ring_clr)
    );

    dring_engine #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .ring_clr  (ring_clr),
        .enabled   (enabled),
        .base      (base),
        .idx_mask  (idx_mask),
        .maxlen    (maxlen),
        .swap_en   (swap_en),
        .wr_idx    (wr_idx),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_rdy   (mem_rdy),
        .mem_rdata (mem_rdata),
        .xfer_valid(xfer_valid),
        .xfer_ready(xfer_ready),
        .xfer_addr (xfer_addr),
        .xfer_len  (xfer_len),
        .xfer_id   (xfer_id),
        .xfer_swap (xfer_swap),
        .xfer_cnt  (xfer_cnt),
        .rd_idx    (rd_idx),
        .err_set   (err_set)
    );

endmodule

// File: rtl/dring_src_engine_chk.sv
module dring_src_engine_chk #(
    parameter int IDX_W = 8,
    parameter int LEN_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ring_clr,
    input logic             enabled,
    input logic [15:0]      maxlen,
    input logic [IDX_W-1:0] rd_idx,
    input logic             mem_req,
    input logic             mem_rdy,
    input logic [31:0]      mem_addr,
    input logic             xfer_valid,
    input logic             xfer_ready,
    input logic [31:0]      xfer_addr,
    input logic [LEN_W-1:0] xfer_len,
    input logic [11:0]      xfer_id,
    input logic [IDX_W:0]   xfer_cnt
);

    AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && !xfer_ready && !ring_clr |=> xfer_valid && $stable(xfer_addr)
            && $stable(xfer_len) && $stable(xfer_id) && $stable(xfer_cnt)); // R10

    AST_RIDX_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && !xfer_ready && !ring_clr |=> $stable(rd_idx)); // R9

    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rdy && !ring_clr |=> mem_req && $stable(mem_addr)); // R4

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled && !mem_req |=> !mem_req); // R3

    AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> xfer_cnt != '0); // R6

    AST_SINGLE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && xfer_cnt == 1 |-> xfer_len <= LEN_W'(maxlen)); // R8

endmodule

bind dring_src_engine dring_src_engine_chk #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ring_clr  (ring_clr),
    .enabled   (enabled),
    .maxlen    (maxlen),
    .rd_idx    (rd_idx),
    .mem_req   (mem_req),
    .mem_rdy   (mem_rdy),
    .mem_addr  (mem_addr),
    .xfer_valid(xfer_valid),
    .xfer_ready(xfer_ready),
    .xfer_addr (xfer_addr),
    .xfer_len  (xfer_len),
    .xfer_id   (xfer_id),
    .xfer_cnt  (xfer_cnt)
);

// File: tb/dring_src_engine_tb.sv
module dring_src_engine_tb;
    localparam int IDX_W = 8;
    localparam int LEN_W = 24;
    localparam logic [31:0] BASE = 32'h0000_1000;
    localparam logic [2:0] A_BASE = 3'd0, A_SIZE = 3'd1, A_CTRL = 3'd2, A_WIDX = 3'd3,
                           A_RIDX = 3'd4, A_STAT = 3'd5, A_SWAP = 3'd6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic mem_req;
    logic [31:0] mem_addr;
    logic mem_rdy = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic xfer_valid;
    logic xfer_ready = 1'b0;
    logic [31:0] xfer_addr;
    logic [LEN_W-1:0] xfer_len;
    logic [11:0] xfer_id;
    logic xfer_swap;
    logic [IDX_W:0] xfer_cnt;

    always #10 clk = ~clk;   // 50 MHz

    dring_src_engine #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_dut (.*);

    typedef struct packed {
        logic [31:0]      a;
        logic [LEN_W-1:0] l;
        logic [11:0]      id;
        logic             sw;
        logic [IDX_W:0]   c;
    } exp_t;

    exp_t expq[$];
    logic [63:0] dmem [0:255];
    int total = 0, bad = 0;
    int host_wr = 0, mask = 0, cur_size = 0;
    int maxlen = 0;
    bit ring_sw = 0, hold_xfer = 0, m_err = 0;
    bit m_open = 0;
    exp_t m_acc;
    int req_seen = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp_v);
        end
    endtask

    function automatic void model_desc(input logic [63:0] d);
        logic [15:0] len;
        len = d[47:32];
        if (int'(len) > maxlen) begin
            m_err = 1;
        end else begin
            if (!m_open) begin
                m_acc.a = d[31:0]; m_acc.id = d[59:48];
                m_acc.l = '0; m_acc.sw = 0; m_acc.c = '0;
            end
            m_acc.l  = m_acc.l + LEN_W'(len);
            m_acc.sw = m_acc.sw | d[60];
            m_acc.c  = m_acc.c + 1'b1;
            m_open   = d[61];
            if (!d[61]) expq.push_back(m_acc);
        end
    endfunction

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        cfg_addr = a;
        #1 v = cfg_rdata;
    endtask

    task automatic put_desc(input logic [31:0] ba, input logic [15:0] len, input bit g,
                            input bit sw, input logic [11:0] id);
        logic [63:0] d;
        d = {2'b00, g, sw, id, len, ba};
        dmem[host_wr] = d;
        model_desc(d);
        host_wr = (host_wr + 1) & mask;
    endtask

    task automatic post_random(input int n, input int over_pct, input int gath_pct);
        for (int k = 0; k < n; k++) begin
            logic [15:0] len;
            bit g;
            bit last;
            last = (k == n - 1);
            if (!last && ($urandom_range(0, 99) < over_pct))
                len = 16'(maxlen + 1 + int'($urandom_range(0, 60)));
            else
                len = 16'($urandom_range(0, maxlen));
            g = last ? 1'b0 : ($urandom_range(0, 99) < gath_pct);
            put_desc($urandom, len, g, 1'($urandom_range(0, 1)), 12'($urandom));
        end
        cfg_write(A_WIDX, 32'(host_wr));
    endtask

    task automatic drain(input string req);
        logic [31:0] v;
        int n;
        n = 0;
        do begin
            cfg_read(A_RIDX, v);
            n++;
        end while (v != 32'(host_wr) && n < 3000);
        chk(v == 32'(host_wr), req, "consumer index after drain", 64'(v), 64'(host_wr));
        chk(expq.size() == 0, req, "requests still expected", 64'(expq.size()), 64'd0);
    endtask

    task automatic set_size(input int s);
        cfg_write(A_SIZE, 32'(s));
        cur_size = s; mask = s - 1; host_wr = 0; m_open = 0;
    endtask

    // memory and mover model, driven away from the active edge
    always @(negedge clk) begin : mon
        bit rx;
        bit mx;
        int slot;
        exp_t e;
        if (!rst_n) begin
            xfer_ready = 1'b0;
            mem_rdy = 1'b0;
        end else begin
            rx = ($urandom_range(0, 3) != 0) && !hold_xfer;
            if (xfer_valid && rx) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R5", "unexpected request", 64'(xfer_addr), 64'd0);
                end else begin
                    e = expq.pop_front();
                    chk(xfer_addr == e.a, (e.c == 1) ? "R5" : "R6", "addr", 64'(xfer_addr), 64'(e.a));
                    chk(xfer_len == e.l, (e.c == 1) ? "R5" : "R6", "len", 64'(xfer_len), 64'(e.l));
                    chk(xfer_id == e.id, (e.c == 1) ? "R5" : "R6", "id", 64'(xfer_id), 64'(e.id));
                    chk(xfer_cnt == e.c, "R6", "count", 64'(xfer_cnt), 64'(e.c));
                    chk(xfer_swap == (e.sw | ring_sw), "R7", "swap", 64'(xfer_swap), 64'(e.sw | ring_sw));
                end
            end
            xfer_ready = rx;
            if (mem_req) req_seen++;
            mx = mem_req && ($urandom_range(0, 2) != 0);
            if (mx) begin
                slot = int'((mem_addr - BASE) >> 3);
                chk(mem_addr[2:0] == 3'd0 && mem_addr >= BASE && slot < cur_size, "R4",
                    "fetch address", 64'(mem_addr), 64'(BASE));
                mem_rdata = dmem[slot & 255];
            end
            mem_rdy = mx;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            bad++; total++;
            $display("FAIL R9 watchdog expired actual=%0d expected=done", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        exp_t held;
        int ridx0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) dmem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        cfg_read(A_RIDX, v); chk(v == 0, "R1", "consumer index", 64'(v), 0);
        cfg_read(A_STAT, v); chk(v == 0, "R1", "status", 64'(v), 0);
        cfg_read(A_CTRL, v); chk(v == 0, "R1", "control", 64'(v), 0);
        chk(!mem_req && !xfer_valid, "R1", "req/valid", {mem_req, xfer_valid}, 0);

        // R3 length limit zero: nothing fetched
        cfg_write(A_BASE, BASE);
        set_size(8);
        dmem[0] = {4'h0, 12'h111, 16'd10, 32'hDEAD_0000};
        cfg_write(A_WIDX, 32'd1);
        req_seen = 0;
        repeat (20) @(negedge clk);
        chk(req_seen == 0, "R3", "fetches while unconfigured", 64'(req_seen), 0);
        cfg_read(A_RIDX, v); chk(v == 0, "R3", "consumer index while unconfigured", 64'(v), 0);
        cfg_read(A_WIDX, v); chk(v == 1, "R11", "producer index before size write", 64'(v), 1);
        set_size(8);
        cfg_read(A_WIDX, v); chk(v == 0, "R11", "producer index after size write", 64'(v), 0);

        // R2 field-preserving control writes
        cfg_write(A_CTRL, 32'h0001_03E8);
        cfg_read(A_CTRL, v); chk(v == 32'h3E8, "R2", "limit write leaves swap", 64'(v), 64'h3E8);
        cfg_write(A_SWAP, 32'd1);
        cfg_read(A_CTRL, v); chk(v == 32'h0001_03E8, "R2", "swap write keeps limit", 64'(v), 64'h103E8);
        cfg_write(A_CTRL, 32'h0000_0200);
        cfg_read(A_CTRL, v); chk(v == 32'h0001_0200, "R2", "limit write keeps swap", 64'(v), 64'h10200);
        cfg_write(A_SWAP, 32'd0);
        cfg_write(A_CTRL, 32'd1000);
        maxlen = 1000;

        // R5 directed: byte count equal to the limit
        put_desc(32'hCAFE_0010, 16'd1000, 1'b0, 1'b0, 12'hABC);
        cfg_write(A_WIDX, 32'(host_wr));
        drain("R5");

        // R4 R5 random single descriptors with wrap
        for (int b = 0; b < 30; b++) begin
            post_random($urandom_range(1, 7), 0, 0);
            drain("R4");
        end

        // R6 random gather runs
        for (int b = 0; b < 30; b++) begin
            post_random($urandom_range(1, 7), 0, 45);
            drain("R6");
        end

        // R7 ring byte-swap enable
        cfg_write(A_SWAP, 32'd1); ring_sw = 1;
        for (int b = 0; b < 6; b++) begin
            post_random($urandom_range(1, 7), 0, 30);
            drain("R7");
        end
        cfg_write(A_SWAP, 32'd0); ring_sw = 0;

        // R8 dropped descriptor outside a run
        put_desc(32'h0000_BAD0, 16'd1001, 1'b0, 1'b0, 12'h001);
        cfg_write(A_WIDX, 32'(host_wr));
        drain("R8");
        cfg_read(A_STAT, v); chk(v == 1, "R8", "error flag set", 64'(v), 1);
        cfg_write(A_STAT, 32'd1); m_err = 0;
        cfg_read(A_STAT, v); chk(v == 0, "R8", "error flag cleared", 64'(v), 0);

        // R8 dropped descriptor inside a run, its gather flag ignored
        put_desc(32'h0000_1110, 16'd100, 1'b1, 1'b0, 12'h0A1);
        put_desc(32'h0000_2220, 16'd2000, 1'b0, 1'b1, 12'h0A2);
        put_desc(32'h0000_3330, 16'd50, 1'b0, 1'b0, 12'h0A3);
        cfg_write(A_WIDX, 32'(host_wr));
        drain("R8");
        cfg_read(A_STAT, v); chk(v == 1, "R8", "error flag in run", 64'(v), 1);
        cfg_write(A_STAT, 32'd1); m_err = 0;

        // R8 random mix
        for (int b = 0; b < 15; b++) begin
            post_random($urandom_range(2, 7), 25, 35);
            drain("R8");
        end
        cfg_read(A_STAT, v); chk(v[0] == m_err, "R8", "error flag random", 64'(v), 64'(m_err));
        cfg_write(A_STAT, 32'd1); m_err = 0;

        // R9 R10 request held by the mover
        hold_xfer = 1;
        cfg_read(A_RIDX, v); ridx0 = int'(v);
        put_desc(32'h0BAD_F00D, 16'd77, 1'b1, 1'b0, 12'h3C3);
        put_desc(32'h0000_0040, 16'd23, 1'b0, 1'b0, 12'h3C4);
        cfg_write(A_WIDX, 32'(host_wr));
        repeat (30) @(negedge clk);
        #1;
        held = {xfer_addr, xfer_len, xfer_id, 1'b0, xfer_cnt};
        repeat (10) @(negedge clk);
        #1;
        chk(xfer_valid, "R10", "valid held", 64'(xfer_valid), 1);
        chk({xfer_addr, xfer_len, xfer_id, 1'b0, xfer_cnt} == held, "R10", "fields held",
            64'(xfer_len), 64'(held.l));
        cfg_read(A_RIDX, v); chk(v == 32'(ridx0), "R9", "index held while waiting", 64'(v), 64'(ridx0));
        hold_xfer = 0;
        drain("R9");

        // R6 run split across two producer writes
        cfg_read(A_RIDX, v); ridx0 = int'(v);
        put_desc(32'h0000_5550, 16'd300, 1'b1, 1'b0, 12'h555);
        cfg_write(A_WIDX, 32'(host_wr));
        repeat (30) @(negedge clk);
        #1;
        chk(!xfer_valid, "R6", "no request while run open", 64'(xfer_valid), 0);
        cfg_read(A_RIDX, v); chk(v == 32'(ridx0), "R9", "index while run open", 64'(v), 64'(ridx0));
        put_desc(32'h0000_6660, 16'd400, 1'b0, 1'b1, 12'h666);
        cfg_write(A_WIDX, 32'(host_wr));
        drain("R6");

        // R11 resize to 4 entries, wrap with the smaller mask
        set_size(4);
        cfg_read(A_RIDX, v); chk(v == 0, "R11", "consumer index after resize", 64'(v), 0);
        for (int b = 0; b < 12; b++) begin
            post_random($urandom_range(1, 3), 0, 40);
            drain("R4");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule